// File: doc/BRIEF.md
# Secure configuration register lock controller

This block holds a bank of 16-bit protected configuration registers, such as key material or memory-protection settings, together with a small set of lock registers that guard them. After reset, trusted boot firmware programs the protected registers over a simple register bus. It then sets lock bits that stop any later write, any later read, or both, to chosen registers. Each protected register has its own write-lock bit and its own read-lock bit. Each lock register also has a seal bit. Once the seal bit is set, that lock register takes no further changes.

Lock bits are sticky. A bus write can only set them. They are cleared only by the main reset or by the designated subsystem reset. The scan-mode, debug-unlock and JTAG-unlock inputs have no effect on the locks: they cannot clear them and they cannot bypass them. Only the authenticated-debug input grants access to a locked register. It does so only while the input is held high, and it never changes the stored lock bits.

The bus is a plain register interface with no handshake. Every access finishes in one cycle, so there is no back-pressure and no valid/ready pair. Read data and the error flag are registered and appear on the cycle after the strobe.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, all of the following are cleared: every protected register, every lock register, `bus_rdata` and `bus_err`.
- R2: The protected registers sit at addresses 0 to 41. A write to one of them that is not write-locked stores `bus_wdata`. A later read that is not read-locked returns that value with `bus_err` low.
- R3: The lock registers sit at addresses 64+i, for i = 0 to 5. Lock register i guards protected registers 7i to 7i+6. Its bit k (k = 0 to 6) is the write-lock for register 7i+k. Its bit 7+k is the read-lock for register 7i+k. Bit 15 is the seal bit. Bit 14 always reads 0. A write ORs the data into the register, so a write can never clear a bit that is already set.
- R4: A write to a write-locked protected register leaves the register unchanged. It also raises `bus_err` for exactly one cycle, on the cycle after the strobe.
- R5: A read of a read-locked protected register returns 0 and raises `bus_err`. The write-lock and the read-lock of a register act independently of each other.
- R6: `scan_mode`, `dbg_unlock` and `jtag_unlock` neither bypass a lock nor clear any lock bit.
- R7: While `auth_dbg` is high, accesses to protected registers ignore their write-locks and read-locks. The stored lock bits stay as they are, so protection applies again once `auth_dbg` falls.
- R8: A write to a sealed lock register is ignored and raises `bus_err`. This holds even while `auth_dbg` is high.
- R9: A one-cycle pulse on `sub_rst` clears every lock register. It leaves the protected registers unchanged.
- R10: Any address that is neither a protected register nor a lock register returns 0 on a read and ignores a write. Both cases raise `bus_err`.
- R11: `bus_rdata` changes only on the cycle after a read strobe. Otherwise it holds its value. `bus_err` is low on the cycle after a cycle with no strobe. When `bus_we` and `bus_re` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main asynchronous reset, active low |
| sub_rst | input | 1 | Designated subsystem reset, synchronous, active high; clears the lock registers |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered one-cycle error flag for a blocked or unmapped access |
| scan_mode | input | 1 | Scan mode; has no effect on the locks |
| dbg_unlock | input | 1 | Plain debug unlock; has no effect on the locks |
| jtag_unlock | input | 1 | JTAG unlock; has no effect on the locks |
| auth_dbg | input | 1 | Authenticated debug; bypasses the locks while high |

## Verification
A write becomes visible to a read strobe issued on the next cycle. The read data and the error flag for a strobe are both due one clock after that strobe. The bench applies every strobe at a falling edge and samples `bus_rdata` and `bus_err` at the following falling edge. This places the sample after exactly one rising edge, with the registered outputs settled. After each write and each subsystem-reset pulse, the bench also checks that `bus_rdata` still holds the last value read. A reference model in the bench predicts both the expected data and the expected error flag for every access.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  // Decoded class of the address on the bus.
  typedef enum logic [1:0] {
    ACC_PROT = 2'd0,
    ACC_LOCK = 2'd1,
    ACC_NONE = 2'd2
  } acc_kind_e;

  // Bits a lock register can hold: write-locks, read-locks and the seal bit.
  function automatic logic [15:0] lock_mask(input int per, input int width);
    logic [15:0] m;
    m = '0;
    for (int b = 0; b < 2 * per; b++) m[b] = 1'b1;
    m[width-1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int NUM_LK = 6,
  parameter int DATA_W = 16,
  parameter int PER_LK = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sub_rst,
  input  logic [NUM_LK-1:0]             lk_we,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_LK-1:0][DATA_W-1:0] lk_q
);
  import cfg_lock_pkg::*;

  localparam logic [DATA_W-1:0] MASK = DATA_W'(lock_mask(PER_LK, DATA_W));

  for (genvar i = 0; i < NUM_LK; i++) begin : g_lk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q[i] <= '0;
      end else if (sub_rst) begin
        lk_q[i] <= '0;
      end else if (lk_we[i]) begin
        // Sticky: bits can only be set.
        lk_q[i] <= lk_q[i] | (wr_data & MASK);
      end
    end
  end
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate #(
  parameter int NUM_LK  = 6,
  parameter int DATA_W  = 16,
  parameter int PER_LK  = 7,
  parameter int ADDR_W  = 7,
  parameter int LK_BASE = 64
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            we,
  input  logic                            re,
  input  logic                            auth,
  input  logic [NUM_LK-1:0][DATA_W-1:0]   lk_q,
  output logic [NUM_LK*PER_LK-1:0]        prot_hit,
  output logic [NUM_LK*PER_LK-1:0]        prot_we,
  output logic [NUM_LK-1:0]               lk_hit,
  output logic [NUM_LK-1:0]               lk_we,
  output logic                            acc_err,
  output logic                            rd_ok
);
  import cfg_lock_pkg::*;

  localparam int NUM_PROT = NUM_LK * PER_LK;
  localparam int SEAL_B   = DATA_W - 1;

  logic [NUM_PROT-1:0] wlk, rlk;
  logic [NUM_LK-1:0]   sealed;
  logic                sel_wlk, sel_rlk, sel_seal;
  acc_kind_e           kind;

  // Spread lock bits per protected register and decode the address.
  for (genvar p = 0; p < NUM_PROT; p++) begin : g_prot
    assign wlk[p]      = lk_q[p / PER_LK][p % PER_LK];
    assign rlk[p]      = lk_q[p / PER_LK][PER_LK + (p % PER_LK)];
    assign prot_hit[p] = (addr == ADDR_W'(p));
  end

  for (genvar i = 0; i < NUM_LK; i++) begin : g_lkd
    assign sealed[i] = lk_q[i][SEAL_B];
    assign lk_hit[i] = (addr == ADDR_W'(LK_BASE + i));
  end

  assign sel_wlk  = |(prot_hit & wlk);
  assign sel_rlk  = |(prot_hit & rlk);
  assign sel_seal = |(lk_hit & sealed);

  always_comb begin
    if (|prot_hit)    kind = ACC_PROT;
    else if (|lk_hit) kind = ACC_LOCK;
    else              kind = ACC_NONE;
  end

  // Only the authenticated input overrides; sealed lock registers stay sealed.
  always_comb begin
    acc_err = 1'b0;
    if (we) begin
      unique case (kind)
        ACC_PROT: acc_err = sel_wlk && !auth;
        ACC_LOCK: acc_err = sel_seal;
        default:  acc_err = 1'b1;
      endcase
    end else if (re) begin
      unique case (kind)
        ACC_PROT: acc_err = sel_rlk && !auth;
        ACC_LOCK: acc_err = 1'b0;
        default:  acc_err = 1'b1;
      endcase
    end
  end

  assign prot_we = prot_hit & {NUM_PROT{we && (!sel_wlk || auth)}};
  assign lk_we   = lk_hit & ~sealed & {NUM_LK{we}};
  assign rd_ok   = re && !we && !acc_err;
endmodule

// File: rtl/cfg_prot_bank.sv
module cfg_prot_bank #(
  parameter int NUM_PROT = 42,
  parameter int DATA_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PROT-1:0]             wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_PROT-1:0][DATA_W-1:0] prot_q
);
  for (genvar p = 0; p < NUM_PROT; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prot_q[p] <= '0;
      else if (wr_en[p]) prot_q[p] <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl #(
  parameter int NUM_LK  = 6,
  parameter int DATA_W  = 16,
  parameter int PER_LK  = 7,
  parameter int ADDR_W  = 7,
  parameter int LK_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              scan_mode,
  input  logic              dbg_unlock,
  input  logic              jtag_unlock,
  input  logic              auth_dbg
);
  localparam int NUM_PROT = NUM_LK * PER_LK;

  logic [NUM_LK-1:0][DATA_W-1:0]   lk_q;
  logic [NUM_PROT-1:0][DATA_W-1:0] prot_q;
  logic [NUM_PROT-1:0]             prot_hit, prot_we;
  logic [NUM_LK-1:0]               lk_hit, lk_we;
  logic                            acc_err, rd_ok;
  logic [DATA_W-1:0]               rd_mux;

  // Mode pins deliberately have no path into lock storage or gating.
  logic unused_modes;
  assign unused_modes = ^{scan_mode, dbg_unlock, jtag_unlock};

  cfg_lock_gate #(
    .NUM_LK(NUM_LK), .DATA_W(DATA_W), .PER_LK(PER_LK),
    .ADDR_W(ADDR_W), .LK_BASE(LK_BASE)
  ) u_gate (
    .addr(bus_addr), .we(bus_we), .re(bus_re), .auth(auth_dbg), .lk_q(lk_q),
    .prot_hit(prot_hit), .prot_we(prot_we), .lk_hit(lk_hit), .lk_we(lk_we),
    .acc_err(acc_err), .rd_ok(rd_ok)
  );

  cfg_lock_store #(.NUM_LK(NUM_LK), .DATA_W(DATA_W), .PER_LK(PER_LK)) u_store (
    .clk(clk), .rst_n(rst_n), .sub_rst(sub_rst),
    .lk_we(lk_we), .wr_data(bus_wdata), .lk_q(lk_q)
  );

  cfg_prot_bank #(.NUM_PROT(NUM_PROT), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(prot_we), .wr_data(bus_wdata), .prot_q(prot_q)
  );

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PROT; p++)
      if (prot_hit[p]) rd_mux = rd_mux | prot_q[p];
    for (int i = 0; i < NUM_LK; i++)
      if (lk_hit[i]) rd_mux = rd_mux | lk_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= acc_err;
      if (bus_re && !bus_we) bus_rdata <= rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cfg_lock_ctrl_chk.sv
module cfg_lock_ctrl_chk #(
  parameter int NUM_LK  = 6,
  parameter int DATA_W  = 16,
  parameter int PER_LK  = 7,
  parameter int ADDR_W  = 7,
  parameter int LK_BASE = 64
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   sub_rst,
  input logic [ADDR_W-1:0]                      bus_addr,
  input logic [DATA_W-1:0]                      bus_wdata,
  input logic                                   bus_we,
  input logic                                   bus_re,
  input logic [DATA_W-1:0]                      bus_rdata,
  input logic                                   bus_err,
  input logic                                   scan_mode,
  input logic                                   dbg_unlock,
  input logic                                   jtag_unlock,
  input logic                                   auth_dbg,
  input logic [NUM_LK-1:0][DATA_W-1:0]          lk_q,
  input logic [NUM_LK*PER_LK-1:0][DATA_W-1:0]   prot_q
);
  localparam int NUM_PROT = NUM_LK * PER_LK;

  logic              is_prot, wl, rl, lk_sealed_hit;
  logic [DATA_W-1:0] tgt_q, hold_val, now_val;
  logic [ADDR_W-1:0] hold_addr;

  always_comb begin
    is_prot = 1'b0; wl = 1'b0; rl = 1'b0; tgt_q = '0; lk_sealed_hit = 1'b0;
    for (int p = 0; p < NUM_PROT; p++) begin
      if (bus_addr == ADDR_W'(p)) begin
        is_prot = 1'b1;
        tgt_q   = prot_q[p];
        wl      = lk_q[p / PER_LK][p % PER_LK];
        rl      = lk_q[p / PER_LK][PER_LK + (p % PER_LK)];
      end
    end
    for (int i = 0; i < NUM_LK; i++)
      if (bus_addr == ADDR_W'(LK_BASE + i) && lk_q[i][DATA_W-1]) lk_sealed_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_val  <= '0;
      hold_addr <= '0;
    end else begin
      hold_val  <= tgt_q;
      hold_addr <= bus_addr;
    end
  end

  always_comb begin
    now_val = '0;
    for (int p = 0; p < NUM_PROT; p++)
      if (hold_addr == ADDR_W'(p)) now_val = prot_q[p];
  end

  a_r4_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_prot && wl && !auth_dbg) |=> (bus_err && now_val == hold_val));

  a_r6_modes_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_prot && wl && !auth_dbg && (scan_mode || dbg_unlock || jtag_unlock))
      |=> (now_val == hold_val));

  a_r5_rd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && is_prot && rl && !auth_dbg) |=> (bus_err && bus_rdata == '0));

  a_r7_auth_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_prot && auth_dbg) |=> (!bus_err && now_val == $past(bus_wdata)));

  a_r3_sticky_locks: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_rst |=> ((lk_q & $past(lk_q)) == $past(lk_q)));

  a_r8_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && lk_sealed_hit && !sub_rst) |=> (bus_err && $stable(lk_q)));

  a_r9_sub_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst |=> (lk_q == '0));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !bus_re) |=> (!bus_err && $stable(bus_rdata)));
endmodule

bind cfg_lock_ctrl cfg_lock_ctrl_chk #(
  .NUM_LK(NUM_LK), .DATA_W(DATA_W), .PER_LK(PER_LK),
  .ADDR_W(ADDR_W), .LK_BASE(LK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_rst(sub_rst), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .scan_mode(scan_mode),
  .dbg_unlock(dbg_unlock), .jtag_unlock(jtag_unlock), .auth_dbg(auth_dbg),
  .lk_q(lk_q), .prot_q(prot_q)
);

// File: tb/cfg_lock_ctrl_tb.sv
module cfg_lock_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROT = 42;
  localparam int NLK   = 6;
  localparam int PER   = 7;
  localparam logic [15:0] LMASK = 16'hBFFF;

  logic clk = 0, rst_n = 0, sub_rst = 0;
  logic [6:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_re = 0, bus_err;
  logic scan_mode = 0, dbg_unlock = 0, jtag_unlock = 0, auth_dbg = 0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [15:0] m_prot [NPROT];
  logic [15:0] m_lk [NLK];
  logic [15:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sub_rst(sub_rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .scan_mode(scan_mode),
    .dbg_unlock(dbg_unlock), .jtag_unlock(jtag_unlock), .auth_dbg(auth_dbg)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_wl(input int a);
    return m_lk[a / PER][a % PER];
  endfunction
  function automatic bit is_rl(input int a);
    return m_lk[a / PER][PER + a % PER];
  endfunction

  function automatic void model_clear_all();
    for (int i = 0; i < NPROT; i++) m_prot[i] = '0;
    for (int i = 0; i < NLK; i++) m_lk[i] = '0;
  endfunction

  // One bus access; model updated, err and rdata checked one cycle later.
  task automatic op(input bit w, input bit r, input int a, input logic [15:0] d,
                    input string tag);
    bit e_err;
    e_err = 0;
    if (w) begin
      if (a < NPROT) begin
        if (is_wl(a) && !auth_dbg) e_err = 1; else m_prot[a] = d;
      end else if (a >= 64 && a < 64 + NLK) begin
        if (m_lk[a-64][15]) e_err = 1; else m_lk[a-64] = m_lk[a-64] | (d & LMASK);
      end else e_err = 1;
    end else if (r) begin
      if (a < NPROT) begin
        if (is_rl(a) && !auth_dbg) begin e_err = 1; exp_rd = '0; end
        else exp_rd = m_prot[a];
      end else if (a >= 64 && a < 64 + NLK) exp_rd = m_lk[a-64];
      else begin e_err = 1; exp_rd = '0; end
    end
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = d; bus_we = w; bus_re = r;
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    check(bus_err == e_err, {tag, " err"}, 16'(bus_err), 16'(e_err));
    check(bus_rdata == exp_rd, {tag, " rdata"}, bus_rdata, exp_rd);
  endtask

  task automatic pulse_sub_rst();
    @(negedge clk); sub_rst = 1;
    @(negedge clk); sub_rst = 0;
    for (int i = 0; i < NLK; i++) m_lk[i] = '0;
    check(bus_err == 0 && bus_rdata == exp_rd, "R9 sub_rst quiet", bus_rdata, exp_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    model_clear_all();
    repeat (3) @(negedge clk);
    check(bus_rdata == 0 && bus_err == 0, "R1 reset outputs", bus_rdata, 16'h0);
    rst_n = 1;
    op(0, 1, 5, 0, "R1 prot reset");
    op(0, 1, 64, 0, "R1 lock reset");
    // R2 basic write/read
    op(1, 0, 3, 16'hA5A5, "R2 write");
    op(0, 1, 3, 0, "R2 readback");
    op(1, 0, 41, 16'h0F0F, "R2 write top");
    op(0, 1, 41, 0, "R2 readback top");
    // R3 lock layout and stickiness
    op(1, 0, 64, 16'h0008, "R3 set wlock reg3");
    op(0, 1, 64, 0, "R3 read lock");
    op(1, 0, 64, 16'h4000, "R3 clear attempt, bit14");
    op(0, 1, 64, 0, "R3 sticky, bit14 zero");
    check(bus_rdata == 16'h0008, "R3 literal value", bus_rdata, 16'h0008);
    // R4 and R6: blocked write, even with mode pins
    scan_mode = 1; dbg_unlock = 1; jtag_unlock = 1;
    op(1, 0, 3, 16'h1234, "R4 R6 blocked write");
    op(0, 1, 3, 0, "R4 R6 unchanged");
    op(0, 1, 64, 0, "R6 lock kept");
    scan_mode = 0; dbg_unlock = 0; jtag_unlock = 0;
    op(1, 0, 2, 16'h2222, "R4 neighbour unlocked");
    // R7 authenticated override
    auth_dbg = 1;
    op(1, 0, 3, 16'h1111, "R7 auth write");
    auth_dbg = 0;
    op(1, 0, 3, 16'h3333, "R7 lock resumes");
    op(0, 1, 3, 0, "R7 value");
    op(0, 1, 64, 0, "R7 lock bits intact");
    // R5 read lock, independence
    op(1, 0, 64, 16'h0400, "R5 rlock reg3");
    op(0, 1, 3, 0, "R5 read blocked");
    op(1, 0, 65, 16'h0080, "R5 rlock reg7 only");
    op(1, 0, 7, 16'h0077, "R5 write allowed");
    op(0, 1, 7, 0, "R5 read blocked reg7");
    auth_dbg = 1;
    op(0, 1, 7, 0, "R5 R7 auth read");
    auth_dbg = 0;
    // R8 seal
    op(1, 0, 64, 16'h8000, "R8 seal");
    op(1, 0, 64, 16'h0001, "R8 sealed write");
    auth_dbg = 1;
    op(1, 0, 64, 16'h0002, "R8 sealed under auth");
    auth_dbg = 0;
    op(0, 1, 64, 0, "R8 value");
    // R10 unmapped
    op(1, 0, 100, 16'hFFFF, "R10 write unmapped");
    op(0, 1, 100, 0, "R10 read unmapped");
    op(0, 1, 42, 0, "R10 read gap");
    // R11 hold and priority
    op(0, 1, 2, 0, "R11 prime");
    repeat (3) @(negedge clk);
    check(bus_rdata == exp_rd && !bus_err, "R11 hold idle", bus_rdata, exp_rd);
    op(1, 1, 2, 16'h5555, "R11 write wins");
    op(0, 1, 2, 0, "R11 written");
    // R9 subsystem reset
    pulse_sub_rst();
    op(0, 1, 64, 0, "R9 locks cleared");
    op(0, 1, 3, 0, "R9 data kept");
    op(1, 0, 64, 16'h0001, "R9 lock writable again");
    // Random phase
    for (int n = 0; n < 600; n++) begin
      int sel, a;
      logic [15:0] d;
      sel = int'($urandom % 10);
      if (sel < 6 || sel == 9) a = int'($urandom % NPROT);
      else if (sel < 8) a = 64 + int'($urandom % NLK);
      else a = 42 + int'($urandom % 22);
      d = 16'($urandom);
      if (a >= 64 && a < 70) begin
        d = d & 16'($urandom) & 16'($urandom);
        if ($urandom % 8 != 0) d[15] = 1'b0;
      end
      scan_mode = 1'($urandom); dbg_unlock = 1'($urandom); jtag_unlock = 1'($urandom);
      auth_dbg = ($urandom % 8 == 0);
      if ($urandom % 2 == 0) op(1, 0, a, d, "R2 R3 R4 R8 rand write");
      else op(0, 1, a, d, "R2 R5 R7 R10 rand read");
      if (n % 50 == 49) pulse_sub_rst();
    end
    auth_dbg = 0; scan_mode = 0; dbg_unlock = 0; jtag_unlock = 0;
    // R1 main reset clears data and locks
    op(1, 0, 10, 16'hBEEF, "R1 pre reset");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model_clear_all(); exp_rd = '0;
    check(bus_rdata == 0 && !bus_err, "R1 reset outputs again", bus_rdata, 16'h0);
    op(0, 1, 10, 0, "R1 data cleared");
    op(0, 1, 65, 0, "R1 locks cleared");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule